// File: doc/BRIEF.md
# Debug Control Register with Interrupt Gating

This block is the single 32-bit debug control register of a processor core, together with the logic that gates the core's interrupt, NMI and soft-reset requests through it. Software writes three enable bits: the interrupt enable, the NMI enable and the soft-reset enable. The register also shows a small set of read-only facts: the kernel/debug endianness, whether data and instruction hardware breakpoints exist, a pending-NMI flag and a live copy of the probe-enable signal from the debug access port.

Interrupt lines are passed to the core only when the interrupt enable bit and the external enable are both set and the core is outside debug mode. An incoming NMI is always recorded as pending. A small state machine with the states `NMI_IDLE` (nothing pending), `NMI_HELD` (pending but blocked) and `NMI_FIRE` (pending and presented to the core) delivers it once delivery is allowed. The transitions are: *arrive-open* (IDLE to FIRE), *arrive-blocked* (IDLE to HELD), *release* (HELD to FIRE when NMI enable is 1 and debug mode is off), *block* (FIRE to HELD when either condition is lost), and *taken* (HELD or FIRE to IDLE on acknowledge with no new NMI in the same cycle). A maskable soft-reset request is suppressed as a whole when the soft-reset enable is 0. A non-maskable request always passes.

All gated outputs are registered. Each output reflects the inputs and register state sampled at the previous rising clock edge.

Top module: `dbgctl_top`

## Requirements
- R1: After a hard reset the register reads IE(bit 4)=1, NMIE(bit 3)=1, pending(bit 2)=0, SRSTE(bit 1)=1, and all gated outputs are 0.
- R2: Bit 29 reads `cfg_big_endian` (1 = big endian), bit 17 reads parameter HAS_DBRK, bit 16 reads parameter HAS_IBRK, and bit 0 reads `probe_en` combinationally. Writes never change these bits.
- R3: Every bit other than 29, 17, 16 and 4..0 reads 0, whatever was written.
- R4: A write with `wr_en`=1 loads bits 4, 3 and 1 of `wr_data` at the next rising edge.
- R5: `irq_out` equals, one cycle later, `irq_raw` ANDed with IE, `ext_ie` and the inverse of `debug_mode`.
- R6: `nmi_raw`=1 sets the pending bit at the next edge, even when NMIE is 0 or debug mode is on.
- R7: `nmi_out` is 1 exactly when an NMI is pending and, at the previous edge, NMIE was 1 and `debug_mode` was 0. A held NMI is released this way once both conditions hold.
- R8: `nmi_ack` clears the pending bit at the next edge unless `nmi_raw` is also 1 in that cycle, in which case the NMI stays pending.
- R9: `debug_mode`=1 forces `irq_out` and `nmi_out` to 0 in the next cycle, whatever the enable bits hold.
- R10: `srst_out` is, one cycle later, `srst_force` OR (`srst_req` AND SRSTE). A masked request produces no reset output at all.
- R11: `soft_rst`=1 at an edge restores the same state as a hard reset, including clearing a pending NMI.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hard reset, asynchronous, active low |
| soft_rst | input | 1 | Soft reset, synchronous, active high |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Register read value |
| cfg_big_endian | input | 1 | Endianness configuration, shown at bit 29 |
| probe_en | input | 1 | Probe-enable from the debug access port |
| debug_mode | input | 1 | Core is in debug mode |
| ext_ie | input | 1 | External interrupt enable from other mechanisms |
| irq_raw | input | N_IRQ | Raw hardware and software interrupt requests |
| irq_out | output | N_IRQ | Gated interrupt requests, registered |
| nmi_raw | input | 1 | Incoming NMI event |
| nmi_ack | input | 1 | Core has taken the NMI |
| nmi_out | output | 1 | Gated NMI request, registered |
| srst_req | input | 1 | Maskable soft-reset request |
| srst_force | input | 1 | Non-maskable soft-reset request |
| srst_out | output | 1 | Gated soft-reset request, registered |

## Verification
The assertions assume that every input is a defined 0 or 1 at each rising edge. They also assume that `nmi_ack` is only meaningful against the pending flag seen in the register, so an acknowledge with nothing pending is harmless. The bench drives all inputs at the falling edge from a fixed-seed random stream that keeps them binary. It mixes acknowledges, new NMIs, debug-mode toggles, register writes and rare soft resets freely, so that the simultaneous-event corners of R8 and R11 occur within the legal input space.

// File: rtl/dbgctl_pkg.sv
package dbgctl_pkg;
    localparam int unsigned REG_W      = 32;
    localparam int unsigned POS_ENDIAN = 29;
    localparam int unsigned POS_DBRK   = 17;
    localparam int unsigned POS_IBRK   = 16;
    localparam int unsigned POS_IE     = 4;
    localparam int unsigned POS_NMIE   = 3;
    localparam int unsigned POS_PEND   = 2;
    localparam int unsigned POS_SRSTE  = 1;
    localparam int unsigned POS_PROBE  = 0;

    typedef enum logic [1:0] {
        NMI_IDLE = 2'd0,
        NMI_HELD = 2'd1,
        NMI_FIRE = 2'd2
    } nmi_state_e;

    typedef struct packed {
        logic ie;
        logic nmie;
        logic srste;
    } ctl_bits_t;

    localparam ctl_bits_t CTL_RESET = '{ie: 1'b1, nmie: 1'b1, srste: 1'b1};
endpackage

// File: rtl/dbgctl_ctl.sv
module dbgctl_ctl
    import dbgctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output ctl_bits_t        ctl
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl <= CTL_RESET;
        end else if (soft_rst) begin
            ctl <= CTL_RESET;
        end else if (wr_en) begin
            ctl.ie    <= wr_data[POS_IE];
            ctl.nmie  <= wr_data[POS_NMIE];
            ctl.srste <= wr_data[POS_SRSTE];
        end
    end
endmodule

// File: rtl/dbgctl_nmi.sv
module dbgctl_nmi
    import dbgctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst,
    input  logic nmi_raw,
    input  logic nmi_ack,
    input  logic nmie,
    input  logic debug_mode,
    output logic pending,
    output logic nmi_out
);
    nmi_state_e state_q, state_d;
    logic       open_w;

    assign open_w = nmie & ~debug_mode;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= NMI_IDLE;
        end else if (soft_rst) begin
            state_q <= NMI_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            NMI_IDLE: begin
                if (nmi_raw) state_d = open_w ? NMI_FIRE : NMI_HELD;
            end
            NMI_HELD: begin
                if (nmi_ack && !nmi_raw) state_d = NMI_IDLE;
                else if (open_w)         state_d = NMI_FIRE;
            end
            NMI_FIRE: begin
                if (nmi_ack && !nmi_raw) state_d = NMI_IDLE;
                else if (!open_w)        state_d = NMI_HELD;
            end
            default: state_d = NMI_IDLE;
        endcase
    end

    always_comb begin
        pending = (state_q != NMI_IDLE);
        nmi_out = (state_q == NMI_FIRE);
    end
endmodule

// File: rtl/dbgctl_gate.sv
module dbgctl_gate #(
    parameter int unsigned N_IRQ = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic [N_IRQ-1:0] irq_raw,
    input  logic             ie,
    input  logic             ext_ie,
    input  logic             debug_mode,
    input  logic             srst_req,
    input  logic             srst_force,
    input  logic             srste,
    output logic [N_IRQ-1:0] irq_out,
    output logic             srst_out
);
    logic irq_open;
    assign irq_open = ie & ext_ie & ~debug_mode;

    for (genvar g = 0; g < N_IRQ; g++) begin : g_line
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        irq_out[g] <= 1'b0;
            else if (soft_rst) irq_out[g] <= 1'b0;
            else               irq_out[g] <= irq_raw[g] & irq_open;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        srst_out <= 1'b0;
        else if (soft_rst) srst_out <= 1'b0;
        else               srst_out <= srst_force | (srst_req & srste);
    end
endmodule

// File: rtl/dbgctl_top.sv
module dbgctl_top
    import dbgctl_pkg::*;
#(
    parameter int unsigned N_IRQ    = 8,
    parameter bit          HAS_DBRK = 1'b1,
    parameter bit          HAS_IBRK = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             wr_en,
    input  logic [31:0]      wr_data,
    output logic [31:0]      rd_data,
    input  logic             cfg_big_endian,
    input  logic             probe_en,
    input  logic             debug_mode,
    input  logic             ext_ie,
    input  logic [N_IRQ-1:0] irq_raw,
    output logic [N_IRQ-1:0] irq_out,
    input  logic             nmi_raw,
    input  logic             nmi_ack,
    output logic             nmi_out,
    input  logic             srst_req,
    input  logic             srst_force,
    output logic             srst_out
);
    ctl_bits_t ctl;
    logic      pending;

    dbgctl_ctl u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .ctl      (ctl)
    );

    dbgctl_nmi u_nmi (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_rst   (soft_rst),
        .nmi_raw    (nmi_raw),
        .nmi_ack    (nmi_ack),
        .nmie       (ctl.nmie),
        .debug_mode (debug_mode),
        .pending    (pending),
        .nmi_out    (nmi_out)
    );

    dbgctl_gate #(.N_IRQ(N_IRQ)) u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_rst   (soft_rst),
        .irq_raw    (irq_raw),
        .ie         (ctl.ie),
        .ext_ie     (ext_ie),
        .debug_mode (debug_mode),
        .srst_req   (srst_req),
        .srst_force (srst_force),
        .srste      (ctl.srste),
        .irq_out    (irq_out),
        .srst_out   (srst_out)
    );

    always_comb begin
        rd_data             = '0;
        rd_data[POS_ENDIAN] = cfg_big_endian;
        rd_data[POS_DBRK]   = HAS_DBRK;
        rd_data[POS_IBRK]   = HAS_IBRK;
        rd_data[POS_IE]     = ctl.ie;
        rd_data[POS_NMIE]   = ctl.nmie;
        rd_data[POS_PEND]   = pending;
        rd_data[POS_SRSTE]  = ctl.srste;
        rd_data[POS_PROBE]  = probe_en;
    end
endmodule

// File: rtl/dbgctl_chk.sv
module dbgctl_chk #(
    parameter int unsigned N_IRQ = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             soft_rst,
    input logic [31:0]      rd_data,
    input logic             debug_mode,
    input logic             ext_ie,
    input logic [N_IRQ-1:0] irq_out,
    input logic             nmi_raw,
    input logic             nmi_ack,
    input logic             nmi_out,
    input logic             srst_force,
    input logic             srst_out
);
    assert_soft_restore_R11: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (rd_data[4:1] == 4'b1101 && !nmi_out && !srst_out));

    assert_debug_block_R9: assert property (@(posedge clk) disable iff (!rst_n)
        debug_mode |=> (irq_out == '0 && !nmi_out));

    assert_pend_latch_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_raw && !soft_rst) |=> rd_data[2]);

    assert_ack_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_ack && !nmi_raw) |=> !rd_data[2]);

    assert_nmi_closed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_data[3] && !nmi_out) |=> !nmi_out);

    assert_nmi_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_out |-> rd_data[2]);

    assert_ie_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_data[4] || !ext_ie) |=> (irq_out == '0));

    assert_srst_mask_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_data[1] && !srst_force) |=> !srst_out);
endmodule

bind dbgctl_top dbgctl_chk #(.N_IRQ(N_IRQ)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .soft_rst   (soft_rst),
    .rd_data    (rd_data),
    .debug_mode (debug_mode),
    .ext_ie     (ext_ie),
    .irq_out    (irq_out),
    .nmi_raw    (nmi_raw),
    .nmi_ack    (nmi_ack),
    .nmi_out    (nmi_out),
    .srst_force (srst_force),
    .srst_out   (srst_out)
);

// File: tb/sim_dbgctl_top.sv
`timescale 1ns/1ps
module sim_dbgctl_top;
    localparam int unsigned NI = 8;

    logic          clk = 1'b0;
    logic          rst_n, soft_rst, wr_en;
    logic [31:0]   wr_data, rd_data;
    logic          cfg_big_endian, probe_en, debug_mode, ext_ie;
    logic [NI-1:0] irq_raw, irq_out;
    logic          nmi_raw, nmi_ack, nmi_out, srst_req, srst_force, srst_out;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    dbgctl_top #(.N_IRQ(NI), .HAS_DBRK(1'b1), .HAS_IBRK(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .cfg_big_endian(cfg_big_endian),
        .probe_en(probe_en), .debug_mode(debug_mode), .ext_ie(ext_ie),
        .irq_raw(irq_raw), .irq_out(irq_out), .nmi_raw(nmi_raw),
        .nmi_ack(nmi_ack), .nmi_out(nmi_out), .srst_req(srst_req),
        .srst_force(srst_force), .srst_out(srst_out)
    );

    // reference model built from the requirements
    logic          m_ie, m_nmie, m_srste, m_pend, m_fire, m_srst;
    logic [NI-1:0] m_irq;

    function automatic logic f_pend_next(logic raw, logic ack, logic pend);
        return raw | (pend & ~ack);
    endfunction

    function automatic logic [31:0] f_word(logic be, logic ie, logic nmie,
                                           logic pend, logic srste, logic probe);
        logic [31:0] w;
        w     = '0;
        w[29] = be;
        w[17] = 1'b1;
        w[16] = 1'b1;
        w[4]  = ie;
        w[3]  = nmie;
        w[2]  = pend;
        w[1]  = srste;
        w[0]  = probe;
        return w;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n || soft_rst) begin
            m_ie <= 1'b1; m_nmie <= 1'b1; m_srste <= 1'b1;
            m_pend <= 1'b0; m_fire <= 1'b0; m_srst <= 1'b0; m_irq <= '0;
        end else begin
            m_irq  <= irq_raw & {NI{m_ie & ext_ie & ~debug_mode}};
            m_srst <= srst_force | (srst_req & m_srste);
            m_pend <= f_pend_next(nmi_raw, nmi_ack, m_pend);
            m_fire <= f_pend_next(nmi_raw, nmi_ack, m_pend) & m_nmie & ~debug_mode;
            if (wr_en) begin
                m_ie <= wr_data[4]; m_nmie <= wr_data[3]; m_srste <= wr_data[1];
            end
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check_model();
        chk("R5 irq_out", 32'(irq_out), 32'(m_irq));
        chk("R7 nmi_out", 32'(nmi_out), 32'(m_fire));
        chk("R10 srst_out", 32'(srst_out), 32'(m_srst));
        chk("R4 rd_data", rd_data,
            f_word(cfg_big_endian, m_ie, m_nmie, m_pend, m_srste, probe_en));
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(logic [31:0] d);
        wr_en = 1'b1; wr_data = d;
        cyc();
        wr_en = 1'b0; wr_data = '0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        rst_n = 1'b0; soft_rst = 1'b0; wr_en = 1'b0; wr_data = '0;
        cfg_big_endian = 1'b1; probe_en = 1'b0; debug_mode = 1'b0; ext_ie = 1'b0;
        irq_raw = '0; nmi_raw = 1'b0; nmi_ack = 1'b0; srst_req = 1'b0; srst_force = 1'b0;
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();
        // R1 reset state
        chk("R1 reset word", rd_data, 32'h2003_001A);
        chk("R1 outputs", {nmi_out, srst_out, irq_out}, '0);
        // R2 probe mirror
        probe_en = 1'b1; #1;
        chk("R2 probe bit", rd_data, 32'h2003_001B);
        probe_en = 1'b0;
        // R2/R3 writes to read-only and reserved bits ignored
        wr(32'hFFFF_FFFF);
        chk("R3 reserved ignore", rd_data, 32'h2003_001A);
        wr(32'h0000_0000);
        chk("R2 R4 clear enables", rd_data, 32'h2003_0000);
        // R6 pending while masked
        nmi_raw = 1'b1; cyc(); nmi_raw = 1'b0;
        chk("R6 pend masked", rd_data, 32'h2003_0004);
        chk("R6 no nmi", 32'(nmi_out), 32'd0);
        // R7 release on enable
        wr(32'h0000_0008);
        chk("R7 held same cycle", 32'(nmi_out), 32'd0);
        cyc();
        chk("R7 released", 32'(nmi_out), 32'd1);
        // R9 debug blocks NMI
        debug_mode = 1'b1; cyc();
        chk("R9 nmi blocked", 32'(nmi_out), 32'd0);
        chk("R9 still pending", 32'(rd_data[2]), 32'd1);
        debug_mode = 1'b0; cyc();
        chk("R7 after debug", 32'(nmi_out), 32'd1);
        // R8 acknowledge
        nmi_ack = 1'b1; cyc(); nmi_ack = 1'b0;
        chk("R8 ack clears", rd_data, 32'h2003_0008);
        chk("R8 nmi off", 32'(nmi_out), 32'd0);
        nmi_raw = 1'b1; cyc();
        nmi_ack = 1'b1; cyc(); nmi_ack = 1'b0; nmi_raw = 1'b0;
        chk("R8 ack with new nmi", 32'(rd_data[2]), 32'd1);
        nmi_ack = 1'b1; cyc(); nmi_ack = 1'b0;
        // R5 / R9 interrupt gating
        wr(32'h0000_0018);
        irq_raw = '1; ext_ie = 1'b1; debug_mode = 1'b1; cyc();
        chk("R9 irq blocked", 32'(irq_out), 32'd0);
        debug_mode = 1'b0; cyc();
        chk("R5 irq pass", 32'(irq_out), 32'h0000_00FF);
        ext_ie = 1'b0; cyc();
        chk("R5 ext disable", 32'(irq_out), 32'd0);
        irq_raw = '0;
        // R10 soft reset masking
        srst_req = 1'b1; cyc();
        chk("R10 masked", 32'(srst_out), 32'd0);
        srst_force = 1'b1; cyc();
        chk("R10 forced", 32'(srst_out), 32'd1);
        srst_req = 1'b0; srst_force = 1'b0;
        // R11 soft reset restores reset state
        wr(32'h0);
        nmi_raw = 1'b1; cyc(); nmi_raw = 1'b0;
        soft_rst = 1'b1; cyc(); soft_rst = 1'b0;
        chk("R11 soft reset word", rd_data, 32'h2003_001A);
        chk("R11 outputs", {nmi_out, srst_out, irq_out}, '0);
        // random phase against model
        for (int i = 0; i < 4000; i++) begin
            check_model();
            irq_raw    = NI'($urandom);
            ext_ie     = ($urandom % 4) != 0;
            if (($urandom % 8) == 0) debug_mode = ~debug_mode;
            nmi_raw    = ($urandom % 12) == 0;
            nmi_ack    = ($urandom % 6) == 0;
            wr_en      = ($urandom % 6) == 0;
            wr_data    = $urandom;
            srst_req   = ($urandom % 5) == 0;
            srst_force = ($urandom % 20) == 0;
            soft_rst   = ($urandom % 64) == 0;
            probe_en   = $urandom % 2;
            cfg_big_endian = ($urandom % 16) != 0;
            cyc();
        end
        check_model();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule